// File: doc/BRIEF.md
# SPI Master with Per-Target Chip-Select Hold

This block is a serial peripheral interface master that moves one word per request. Each chip-select output has its own configuration, supplied on input ports: word length, clock idle level, clock phase, clock divider, and what happens to the select line once the word is complete. The host presents a transmit word and a target index, then pulses `start`. The engine asserts the target's active-low select, runs the serial clock, and shifts the word out most significant bit first while it collects `miso`. It then returns the received word, right-aligned, with a one-cycle `done` pulse.

The select line can be released when the word ends. It can also stay low, so that a slave keeps seeing one frame across several words, until a transfer is started on a different target. A separate force flag releases the line after every word and overrides the hold request. Phase uses an inverted sense. When the phase flag is 0, data changes on the leading clock edge. When it is 1, data is captured on the leading edge.

Top module: `spi_cs_hold_master`

## Requirements
- R1: The 4-bit length code sets the word length to 8 plus the code, for codes 0 to 8 (8 to 16 bits). Codes 9 to 15 give 8 bits.
- R2: `mosi` sends the word most significant bit first. `rx_word` holds the received bits right-aligned, with all bits above the word length at zero.
- R3: While no transfer runs, `sclk` does not change. From the cycle after an accepted `start`, `sclk` sits at the target's idle-level flag (0 low, 1 high) until its first edge.
- R4: Phase flag 0: the master drives each bit on the leading `sclk` edge and samples `miso` on the trailing edge, and no bit is placed on `mosi` before the first edge. Phase flag 1: the first bit is on `mosi` before the first edge, the master samples on leading edges, and it changes `mosi` on trailing edges.
- R5: `sclk` toggles every DIV+1 system cycles, with exactly twice the word length toggles per word. `done` rises (2N+1)(DIV+1) cycles after the clock edge that accepts `start`, and it lasts one cycle.
- R6: The target's select is low from the cycle after the accepted `start`. The first `sclk` edge comes DIV+1 cycles later, and at least DIV+1 cycles separate the last edge from `done`.
- R7: With the hold flag 1 and the force flag 0, the select stays low after `done`. A following word to the same target keeps it low throughout. A word to another target raises it when that word is accepted.
- R8: With the force flag 1, the select rises at `done` whatever the hold flag is.
- R9: With both flags 0, the select rises at `done`.
- R10: `busy` is high from the cycle after an accepted `start` until the `done` cycle, when it is low. A `start` that arrives while `busy` is high changes neither the timing, nor the data, nor any select line.
- R11: After reset every select line is high, `sclk` is low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one word; accepted only while idle |
| cs_sel | input | CSW | Target chip-select index |
| tx_word | input | 16 | Word to send, right-aligned |
| cfg_len | input | NCS*4 | Per-target length code |
| cfg_div | input | NCS*DW | Per-target half-period divider DIV |
| cfg_cpol | input | NCS | Per-target clock idle level |
| cfg_ncpha | input | NCS | Per-target phase flag (inverted sense) |
| cfg_hold | input | NCS | Per-target keep-select-low flag |
| cfg_drop | input | NCS | Per-target force-release flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | 16 | Received word, right-aligned, zero-extended |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Every result is counted in system cycles from the clock edge that accepts `start`. The select and idle clock level are due one cycle later, the first `sclk` edge DIV+1 cycles later, and each further edge DIV+1 cycles after the one before. `done` and the final select level are due (2N+1)(DIV+1) cycles after that edge. The bench raises `start` on a falling clock edge and then samples on each falling edge, numbering the samples from 1. It expects the first toggle at sample DIV+2 and `done` at sample (2N+1)(DIV+1)+1. A behavioural slave that follows the configured phase supplies `miso` and collects `mosi`, so that the data checks in both directions agree with those cycle counts.

// File: rtl/spi_cs_hold_master.sv
module spi_cs_hold_master #(
  parameter int NCS = 4,
  parameter int DW  = 8,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CSW-1:0]    cs_sel,
  input  logic [15:0]       tx_word,
  input  logic [NCS*4-1:0]  cfg_len,
  input  logic [NCS*DW-1:0] cfg_div,
  input  logic [NCS-1:0]    cfg_cpol,
  input  logic [NCS-1:0]    cfg_ncpha,
  input  logic [NCS-1:0]    cfg_hold,
  input  logic [NCS-1:0]    cfg_drop,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rx_word,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TRAIL} st_t;

  st_t            st;
  logic [CSW-1:0] cur, held;
  logic           held_v;
  logic [DW-1:0]  div, cnt;
  logic           ncpha, hold, drop;
  logic [4:0]     nbits;
  logic [5:0]     edges;
  logic [15:0]    tsr, rsr;

  wire [3:0]    sel_code = cfg_len[int'(cs_sel)*4 +: 4];
  wire [4:0]    sel_n    = (sel_code <= 4'd8) ? (5'd8 + {1'b0, sel_code}) : 5'd8;
  wire [DW-1:0] sel_div  = cfg_div[int'(cs_sel)*DW +: DW];
  wire [15:0]   aligned  = tx_word << (5'd16 - sel_n);

  wire lead      = ~edges[0];
  wire last_edge = (edges == ({nbits, 1'b0} - 6'd1));
  wire do_change = ncpha ? (~lead & ~last_edge) : lead;
  wire do_sample = ncpha ? lead : ~lead;
  wire tick      = (cnt == '0);

  assign busy = (st != S_IDLE);

  logic [NCS-1:0] act;
  always_comb begin
    act = '0;
    if (st != S_IDLE) act[cur] = 1'b1;
    else if (held_v)  act[held] = 1'b1;
  end
  assign cs_n = ~act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; held <= '0; held_v <= 1'b0;
      div <= '0; cnt <= '0; ncpha <= 1'b0; hold <= 1'b0; drop <= 1'b0;
      nbits <= 5'd8; edges <= '0; tsr <= '0; rsr <= '0;
      sclk <= 1'b0; mosi <= 1'b0; done <= 1'b0; rx_word <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_RUN;
          cur    <= cs_sel;
          held_v <= 1'b0;
          div    <= sel_div;
          cnt    <= sel_div;
          ncpha  <= cfg_ncpha[cs_sel];
          hold   <= cfg_hold[cs_sel];
          drop   <= cfg_drop[cs_sel];
          nbits  <= sel_n;
          edges  <= '0;
          rsr    <= '0;
          sclk   <= cfg_cpol[cs_sel];
          if (cfg_ncpha[cs_sel]) begin
            mosi <= aligned[15];
            tsr  <= aligned << 1;
          end else begin
            tsr  <= aligned;
          end
        end
        S_RUN: if (!tick) cnt <= cnt - 1'b1;
        else begin
          cnt   <= div;
          sclk  <= ~sclk;
          edges <= edges + 6'd1;
          if (do_change) begin
            mosi <= tsr[15];
            tsr  <= tsr << 1;
          end
          if (do_sample) rsr <= {rsr[14:0], miso};
          if (last_edge) st <= S_TRAIL;
        end
        S_TRAIL: if (!tick) cnt <= cnt - 1'b1;
        else begin
          st      <= S_IDLE;
          done    <= 1'b1;
          rx_word <= rsr;
          if (hold && !drop) begin
            held_v <= 1'b1;
            held   <= cur;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cs_hold_master_chk.sv
module spi_cs_hold_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           sclk,
  input logic [NCS-1:0] cs_n
);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_low_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_one_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_select_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~cs_n) == 1));

  assert_idle_clock_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sclk));

endmodule

bind spi_cs_hold_master spi_cs_hold_master_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/spi_cs_hold_master_tb.sv
`timescale 1ns/1ps
module spi_cs_hold_master_tb;
  localparam int NCS = 4;
  localparam int DW  = 8;
  localparam int CSW = 2;

  logic clk = 0, rst_n = 0, start = 0, miso = 0;
  logic [CSW-1:0] cs_sel = '0;
  logic [15:0] tx_word = '0;
  logic [NCS*4-1:0] cfg_len = '0;
  logic [NCS*DW-1:0] cfg_div = '0;
  logic [NCS-1:0] cfg_cpol = '0, cfg_ncpha = '0, cfg_hold = '0, cfg_drop = '0;
  logic busy, done, sclk, mosi;
  logic [15:0] rx_word;
  logic [NCS-1:0] cs_n;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_cs_hold_master #(.NCS(NCS), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_sel(cs_sel), .tx_word(tx_word),
    .cfg_len(cfg_len), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_ncpha(cfg_ncpha),
    .cfg_hold(cfg_hold), .cfg_drop(cfg_drop), .busy(busy), .done(done),
    .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  // behavioural slave
  int s_sel = 0;
  logic s_cpol = 0, s_ncpha = 0, s_lead = 0;
  logic [15:0] s_sh = '0, s_rx = '0;
  always @(sclk) begin
    #1;
    if (cs_n[s_sel] === 1'b0) begin
      if (sclk !== s_cpol) begin
        s_lead = 1;
        if (s_ncpha) s_rx = {s_rx[14:0], mosi};
        else begin miso = s_sh[15]; s_sh = s_sh << 1; end
      end else if (s_lead) begin
        if (s_ncpha) begin s_sh = s_sh << 1; miso = s_sh[15]; end
        else s_rx = {s_rx[14:0], mosi};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int cs, input logic [3:0] code, input logic [7:0] dv,
                         input logic cp, input logic ph, input logic hd, input logic dr);
    cfg_len[cs*4 +: 4] = code;
    cfg_div[cs*DW +: DW] = dv;
    cfg_cpol[cs] = cp; cfg_ncpha[cs] = ph; cfg_hold[cs] = hd; cfg_drop[cs] = dr;
  endtask

  task automatic xfer(input int cs, input logic [15:0] w, input logic [15:0] sw,
                      input bit inject, input int other);
    int n, dv, t, cyc, tog, first, last;
    logic prev;
    bit busy_bad, cs_bad, oth_bad;
    logic [15:0] mask;
    n  = (cfg_len[cs*4 +: 4] <= 4'd8) ? 8 + int'(cfg_len[cs*4 +: 4]) : 8;
    dv = int'(cfg_div[cs*DW +: DW]);
    t  = (2*n + 1) * (dv + 1);
    mask = 16'((32'd1 << n) - 1);
    s_sel = cs; s_cpol = cfg_cpol[cs]; s_ncpha = cfg_ncpha[cs]; s_lead = 0;
    s_sh = sw << (16 - n); s_rx = '0;
    if (s_ncpha) miso = s_sh[15];
    @(negedge clk);
    start = 1; cs_sel = CSW'(cs); tx_word = w;
    @(negedge clk);
    start = 0;
    cyc = 1; tog = 0; first = 0; last = 0; prev = sclk;
    busy_bad = 0; cs_bad = 0; oth_bad = 0;
    while (!done && cyc < 5000) begin
      if (cyc == 1) begin
        chk("R3 idle level before first edge", 32'(sclk), 32'(cfg_cpol[cs]));
        chk("R6 select low after accept", 32'(cs_n[cs]), 0);
        prev = sclk;
      end else if (sclk !== prev) begin
        tog++; if (tog == 1) first = cyc; last = cyc; prev = sclk;
      end
      if (!busy) busy_bad = 1;
      if (cs_n[cs] !== 1'b0) cs_bad = 1;
      if (inject && cs_n[other] === 1'b0) oth_bad = 1;
      if (inject && cyc == 5) begin start = 1; cs_sel = CSW'(other); tx_word = ~w; end
      if (cyc == 6) start = 0;
      @(negedge clk); cyc++;
    end
    chk("R5 R1 done cycle", 32'(cyc), 32'(t + 1));
    chk("R6 first edge after select", 32'(first), 32'(dv + 2));
    chk("R5 toggle count", 32'(tog), 32'(2*n));
    chk("R6 last edge before done", 32'(last), 32'(2*n*(dv + 1) + 1));
    chk("R2 R4 received word", 32'(rx_word), 32'(sw & mask));
    chk("R2 R4 slave received", 32'(s_rx & mask), 32'(w & mask));
    chk("R10 busy through transfer", 32'(busy_bad), 0);
    chk("R10 busy low at done", 32'(busy), 0);
    chk("R6 select held during word", 32'(cs_bad), 0);
    if (inject) chk("R10 ignored start left other select", 32'(oth_bad), 0);
    chk("R7 R8 R9 select after done", 32'(cs_n[cs]),
        32'((cfg_drop[cs] || !cfg_hold[cs]) ? 1 : 0));
    @(negedge clk);
    chk("R5 done one cycle", 32'(done), 0);
  endtask

  task automatic t_reset;
    chk("R11 selects high", 32'(cs_n), 32'hF);
    chk("R11 sclk low", 32'(sclk), 0);
    chk("R11 busy low", 32'(busy), 0);
    chk("R11 done low", 32'(done), 0);
  endtask

  task automatic t_modes;
    set_cfg(0, 4'd0, 8'd0, 0, 0, 0, 0); xfer(0, 16'h00A5, 16'h003C, 0, 0);   // R4 R9
    set_cfg(1, 4'd8, 8'd2, 1, 1, 0, 0); xfer(1, 16'hC3A1, 16'h5E17, 0, 0);   // R1 16 bits
    set_cfg(2, 4'd4, 8'd1, 0, 1, 0, 0); xfer(2, 16'hFABC, 16'hF123, 0, 0);   // R1 12 bits
    set_cfg(3, 4'd5, 8'd3, 1, 0, 0, 0); xfer(3, 16'h1B6D, 16'h0F0F, 0, 0);   // R1 13 bits
  endtask

  task automatic t_reserved;
    set_cfg(0, 4'd12, 8'd1, 0, 1, 0, 0); xfer(0, 16'h12C9, 16'hFF96, 0, 0);  // R1 reserved
  endtask

  task automatic t_hold;
    set_cfg(1, 4'd0, 8'd1, 1, 1, 1, 0);
    xfer(1, 16'h0055, 16'h00AA, 0, 0);
    repeat (6) @(negedge clk);
    chk("R7 select still low while idle", 32'(cs_n[1]), 0);
    xfer(1, 16'h0033, 16'h00CC, 0, 0);
    set_cfg(2, 4'd0, 8'd0, 0, 0, 0, 0);
    @(negedge clk);
    start = 1; cs_sel = 2'd2; tx_word = 16'h0011;
    s_sel = 2; s_cpol = 0; s_ncpha = 0; s_lead = 0; s_sh = 16'h0000; s_rx = '0;
    @(negedge clk); start = 0;
    chk("R7 held select released by other target", 32'(cs_n[1]), 1);
    chk("R7 new target selected", 32'(cs_n[2]), 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R9 select high after plain word", 32'(cs_n[2]), 1);
  endtask

  task automatic t_drop;
    set_cfg(0, 4'd1, 8'd0, 0, 0, 1, 1); xfer(0, 16'h01F0, 16'h0155, 0, 0);  // R8
  endtask

  task automatic t_ignore;
    set_cfg(3, 4'd3, 8'd2, 0, 0, 0, 0);
    set_cfg(2, 4'd0, 8'd0, 1, 1, 0, 0);
    xfer(3, 16'h0A5A, 16'h0369, 1, 2);                                       // R10
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_modes();
    t_reserved();
    t_hold();
    t_drop();
    t_ignore();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule